// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes and hours in 24-hour form, a day-of-week count, the day of the month, the month, a two-digit year and a two-digit century. A free-running prescaler counts a slow oscillator enable (32.768 kHz by default). Its full wrap gives the one-second tick, and a wrap of its low bits gives a 512 Hz test strobe. Each tick advances the seconds field. Carries then ripple upward through the fields. The date limit depends on the month, and February has a leap-year adjustment that only needs to hold through 2100.

A one-cycle load pulse writes a complete time image into all fields at once and restarts the prescaler, so the first second after a load lasts a full second. A stop input freezes both the prescaler and the calendar. The whole live count is always visible on parallel outputs.

Top module: `rtc_calendar`

## Requirements
- R1: While reset is held, the outputs read 00:00:00, day-of-week 01, date 01, month 01, year 00, century 00, and neither the tick nor the strobe pulses.
- R2: A high `load_i` on one clock edge makes every field equal its load input on the following cycle and clears the prescaler. The first seconds advance then comes exactly 2^DIV_W counted enables later.
- R3: While running, seconds advance by one BCD step once per 2^DIV_W cycles that have `osc_en_i` high (32768 by default). The step carries the units digit from 9 into the tens digit, for example 09 to 10.
- R4: Seconds 59 roll to 00 and advance minutes. Minutes 59 roll to 00 and advance hours.
- R5: Hours 23 roll to 00 and advance both the date and the day-of-week on the same edge.
- R6: Day-of-week counts 01 to 07, and 07 rolls to 01.
- R7: Months 04, 06, 09 and 11 roll the date from 30 to 01. All other months except February roll from 31 to 01. Each date rollover advances the month.
- R8: In February the date rolls after 28 when the year value is not divisible by 4, and after 29 when it is (year 00 counts as divisible).
- R9: Month 12 rolls to 01 and advances the year. Year 99 rolls to 00 and advances the century. Century 39 rolls to 00.
- R10: While `osc_stop_i` is 1, no field changes and the prescaler holds its count. When `osc_stop_i` is cleared, counting resumes from the held count.
- R11: `strobe_o` pulses once per 2^STB_W counted enables (64 by default, giving 512 Hz). `tick_o` pulses once per 2^DIV_W counted enables. Neither output pulses while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | One-cycle enable from the 32.768 kHz timebase |
| osc_stop_i | input | 1 | 1 halts the prescaler and the calendar |
| load_i | input | 1 | Load pulse for the full time image |
| ld_sec_i | input | 8 | Seconds to load, BCD |
| ld_min_i | input | 8 | Minutes to load, BCD |
| ld_hr_i | input | 8 | Hours to load, BCD 00-23 |
| ld_dow_i | input | 8 | Day-of-week to load, BCD 01-07 |
| ld_date_i | input | 8 | Date to load, BCD 01-31 |
| ld_mon_i | input | 8 | Month to load, BCD 01-12 |
| ld_yr_i | input | 8 | Year to load, BCD 00-99 |
| ld_cen_i | input | 8 | Century to load, BCD 00-39 |
| sec_o | output | 8 | Live seconds |
| min_o | output | 8 | Live minutes |
| hr_o | output | 8 | Live hours |
| dow_o | output | 8 | Live day-of-week |
| date_o | output | 8 | Live date |
| mon_o | output | 8 | Live month |
| yr_o | output | 8 | Live year |
| cen_o | output | 8 | Live century |
| tick_o | output | 1 | One-second pulse |
| strobe_o | output | 1 | Frequency-test strobe |

## Verification
Each carry stage is driven by loading a time image one second before a boundary and letting a single full second elapse. Images just short of a boundary are paired with images at the boundary, so a wrong compare value and a missing carry give different results. For February the year is varied over non-multiples of 4, multiples of 4 with an odd or an even tens digit, and year 00. This catches a leap test that looks only at the units digit. A stopped interval longer than a second, followed by a release, shows whether the prescaler freezes or restarts. Pulse counts over one full prescaler period fix both the tick rate and the strobe rate.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef logic [7:0] bcd8_t;

  localparam int unsigned CHAIN_N  = 7;
  localparam int unsigned IDX_SEC  = 0;
  localparam int unsigned IDX_MIN  = 1;
  localparam int unsigned IDX_HR   = 2;
  localparam int unsigned IDX_DATE = 3;
  localparam int unsigned IDX_MON  = 4;
  localparam int unsigned IDX_YR   = 5;
  localparam int unsigned IDX_CEN  = 6;

  // add one to a two-digit packed BCD value
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // year divisible by four (sufficient up to 2100)
  function automatic logic leap_year(input bcd8_t yr);
    logic [6:0] b;
    b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic bcd8_t month_last(input bcd8_t mon, input bcd8_t yr);
    bcd8_t r;
    case (mon)
      8'h02:                      r = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  // value a chained field restarts from after its last value
  function automatic bcd8_t chain_first(input int unsigned idx);
    return (idx == IDX_DATE || idx == IDX_MON) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W = 15,
  parameter int unsigned STB_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic halt_i,
  input  logic clr_i,
  output logic sec_tick_o,
  output logic strobe_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             run;

  assign run        = en_i & ~halt_i;
  assign sec_tick_o = run & (&cnt_q);
  assign strobe_o   = run & (&cnt_q[STB_W-1:0]);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R10
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !clr_i) |=> $stable(cnt_q));

  // R2
  clear_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter bcd8_t FIRST = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_i,
  input  bcd8_t ld_val_i,
  input  logic  step_i,
  input  bcd8_t last_i,
  output bcd8_t q_o,
  output logic  at_last_o
);

  bcd8_t q_q, q_d;

  assign q_o       = q_q;
  assign at_last_o = (q_q == last_i);

  always_comb begin
    q_d = q_q;
    if (ld_i)        q_d = ld_val_i;
    else if (step_i) q_d = at_last_o ? FIRST : bcd_inc(q_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= FIRST;
    else         q_q <= q_d;
  end

  // R4
  wrap_to_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && at_last_o) |=> (q_o == FIRST));

  // R3
  digit_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && !at_last_o && q_o[3:0] == 4'd9) |=> (q_o[3:0] == 4'd0));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W = 15,
  parameter int unsigned STB_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic       osc_stop_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hr_i,
  input  logic [7:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_yr_i,
  input  logic [7:0] ld_cen_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o,
  output logic [7:0] cen_o,
  output logic       tick_o,
  output logic       strobe_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic sec_tick;

  rtc_prescaler #(.DIV_W(DIV_W), .STB_W(STB_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_q),
    .en_i       (osc_en_i),
    .halt_i     (osc_stop_i),
    .clr_i      (load_i),
    .sec_tick_o (sec_tick),
    .strobe_o   (strobe_o)
  );

  assign tick_o = sec_tick;

  logic [CHAIN_N-1:0][7:0] ld_v, q_v, last_v;
  logic [CHAIN_N-1:0]      adv, at_last;
  logic                    dow_last;

  assign ld_v = {ld_cen_i, ld_yr_i, ld_mon_i, ld_date_i, ld_hr_i, ld_min_i, ld_sec_i};

  always_comb begin
    last_v[IDX_SEC]  = 8'h59;
    last_v[IDX_MIN]  = 8'h59;
    last_v[IDX_HR]   = 8'h23;
    last_v[IDX_DATE] = month_last(q_v[IDX_MON], q_v[IDX_YR]);
    last_v[IDX_MON]  = 8'h12;
    last_v[IDX_YR]   = 8'h99;
    last_v[IDX_CEN]  = 8'h39;
  end

  for (genvar i = 0; i < CHAIN_N; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign adv[i] = sec_tick;
    end else begin : g_link
      assign adv[i] = adv[i-1] & at_last[i-1];
    end

    rtc_bcd_field #(.FIRST(chain_first(i))) u_fld (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_q),
      .ld_i      (load_i),
      .ld_val_i  (ld_v[i]),
      .step_i    (adv[i]),
      .last_i    (last_v[i]),
      .q_o       (q_v[i]),
      .at_last_o (at_last[i])
    );
  end

  rtc_bcd_field #(.FIRST(8'h01)) u_dow (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_q),
    .ld_i      (load_i),
    .ld_val_i  (ld_dow_i),
    .step_i    (adv[IDX_DATE]),
    .last_i    (8'h07),
    .q_o       (dow_o),
    .at_last_o (dow_last)
  );

  assign sec_o  = q_v[IDX_SEC];
  assign min_o  = q_v[IDX_MIN];
  assign hr_o   = q_v[IDX_HR];
  assign date_o = q_v[IDX_DATE];
  assign mon_o  = q_v[IDX_MON];
  assign yr_o   = q_v[IDX_YR];
  assign cen_o  = q_v[IDX_CEN];

  // R10
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (osc_stop_i && !load_i) |=> $stable({cen_o, yr_o, mon_o, date_o, dow_o, hr_o, min_o, sec_o}));

  // R2
  load_image_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    load_i |=> (sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) &&
                hr_o == $past(ld_hr_i) && dow_o == $past(ld_dow_i) &&
                date_o == $past(ld_date_i) && mon_o == $past(ld_mon_i) &&
                yr_o == $past(ld_yr_i) && cen_o == $past(ld_cen_i)));

  // R8
  leap_feb_end_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (adv[IDX_DATE] && !load_i && mon_o == 8'h02 && date_o == 8'h29)
      |=> (mon_o == 8'h03 && date_o == 8'h01));

  // R6
  dow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (adv[IDX_DATE] && !load_i && dow_o == 8'h07) |=> (dow_o == 8'h01));

  // R5
  day_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (sec_tick && !load_i && hr_o == 8'h23 && min_o == 8'h59 && sec_o == 8'h59)
      |=> (hr_o == 8'h00 && !$stable(date_o) && !$stable(dow_o)));

endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;

  localparam int unsigned DIV_W = 8;
  localparam int unsigned STB_W = 2;
  localparam int unsigned SEC_CYC = 1 << DIV_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b1;
  logic osc_stop = 1'b0;
  logic load = 1'b0;
  logic [7:0] l_sec = '0, l_min = '0, l_hr = '0, l_dow = '0;
  logic [7:0] l_date = '0, l_mon = '0, l_yr = '0, l_cen = '0;
  logic [7:0] sec, mnt, hr, dow, date, mon, yr, cen;
  logic tick, strobe;

  always #10 clk = ~clk;

  rtc_calendar #(.DIV_W(DIV_W), .STB_W(STB_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .osc_stop_i(osc_stop),
    .load_i(load), .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hr_i(l_hr),
    .ld_dow_i(l_dow), .ld_date_i(l_date), .ld_mon_i(l_mon), .ld_yr_i(l_yr),
    .ld_cen_i(l_cen), .sec_o(sec), .min_o(mnt), .hr_o(hr), .dow_o(dow),
    .date_o(date), .mon_o(mon), .yr_o(yr), .cen_o(cen),
    .tick_o(tick), .strobe_o(strobe)
  );

  typedef struct {
    int unsigned at;
    logic [63:0] val;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int unsigned cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // image order: century, year, month, date, dow, hour, minute, second
  function automatic logic [63:0] img(input logic [7:0] c, y, m, d, w, h, mi, s);
    return {c, y, m, d, w, h, mi, s};
  endfunction

  function automatic logic [63:0] live();
    return {cen, yr, mon, date, dow, hr, mnt, sec};
  endfunction

  task automatic compare(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected images when their cycle is reached
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      compare(it.tag, live(), it.val);
    end
  end

  task automatic push(input int unsigned at, input logic [63:0] v, input string tag);
    exp_t it;
    it.at = at; it.val = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic apply_load(input logic [63:0] v, input logic stop);
    @(negedge clk);
    {l_cen, l_yr, l_mon, l_date, l_dow, l_hr, l_min, l_sec} = v;
    load = 1'b1;
    osc_stop = stop;
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  // load an image, let exactly one second pass, expect the advanced image
  task automatic one_second(input logic [63:0] start, input logic [63:0] exp, input string tag);
    apply_load(start, 1'b0);
    push(cyc, start, {tag, " load"});
    push(cyc + SEC_CYC - 1, start, {tag, " before tick"});
    push(cyc + SEC_CYC, exp, tag);
    @(negedge clk);
    load = 1'b0;
    drain();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int ns, nt;
    // R1 reset image
    repeat (3) @(negedge clk);
    compare("R1 reset image", live(), img(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
    compare("R1 no pulses", {62'd0, tick, strobe}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 units digit carry into tens
    one_second(img(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h09),
               img(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h10), "R3 09->10");
    // R4 seconds and minutes rollover
    one_second(img(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h59),
               img(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h21, 8'h00), "R4 sec wrap");
    one_second(img(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h11, 8'h00, 8'h00), "R4 min wrap");
    // R5 hour rollover moves date and day
    one_second(img(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h03, 8'h16, 8'h04, 8'h00, 8'h00, 8'h00), "R5 day change");
    // R6 day-of-week 7 -> 1
    one_second(img(8'h20, 8'h24, 8'h03, 8'h16, 8'h07, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h03, 8'h17, 8'h01, 8'h00, 8'h00, 8'h00), "R6 dow wrap");
    // R7 month lengths
    one_second(img(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00), "R7 april end");
    one_second(img(8'h20, 8'h24, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h12, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00), "R7 november end");
    one_second(img(8'h20, 8'h24, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h01, 8'h31, 8'h03, 8'h00, 8'h00, 8'h00), "R7 january 30");
    one_second(img(8'h20, 8'h24, 8'h01, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h02, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R7 january end");
    // R8 February by year
    one_second(img(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00), "R8 year 23");
    one_second(img(8'h20, 8'h10, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h10, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00), "R8 year 10");
    one_second(img(8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00), "R8 year 24");
    one_second(img(8'h20, 8'h12, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h12, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00), "R8 year 12");
    one_second(img(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00), "R8 year 00");
    one_second(img(8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h24, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R8 leap end");
    // R9 year, century
    one_second(img(8'h20, 8'h24, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59),
               img(8'h20, 8'h25, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00), "R9 year end");
    one_second(img(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59),
               img(8'h21, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00), "R9 century step");
    one_second(img(8'h39, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59),
               img(8'h00, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00), "R9 century wrap");

    // R11 pulse rates over one full prescaler period
    apply_load(img(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h08, 8'h00, 8'h00), 1'b0);
    @(negedge clk);
    load = 1'b0;
    ns = 0; nt = 0;
    for (int k = 0; k < SEC_CYC; k++) begin
      @(negedge clk);
      if (strobe) ns++;
      if (tick) nt++;
    end
    compare("R11 strobe count", 64'(ns), 64'(SEC_CYC >> STB_W));
    compare("R11 tick count", 64'(nt), 64'd1);

    // R10 stop holds everything, release resumes for a full second (R2)
    apply_load(img(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h08, 8'h00, 8'h05), 1'b1);
    push(cyc, img(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h08, 8'h00, 8'h05), "R2 load while stopped");
    @(negedge clk);
    load = 1'b0;
    ns = 0; nt = 0;
    for (int k = 0; k < 3 * SEC_CYC; k++) begin
      @(negedge clk);
      if (strobe) ns++;
      if (tick) nt++;
    end
    compare("R10 frozen image", live(), img(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h08, 8'h00, 8'h05));
    compare("R11 no pulses stopped", 64'(ns + nt), 64'd0);
    osc_stop = 1'b0;
    push(cyc + SEC_CYC - 1, img(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h08, 8'h00, 8'h05), "R10 resume early");
    push(cyc + SEC_CYC, img(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h08, 8'h00, 8'h06), "R10 resume tick");
    drain();

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule